// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Sequencer

This block turns single read and write requests from a simple processor core into bus cycles on an external local bus. On that bus a 20-bit address and 16-bit data share the same pins at different times. Each cycle has four basic clock states. The first state presents the address and pulses the address latch enable. The middle states assert the read or write strobe and can be stretched by an external ready line. The last state removes the strobe and hands read data back to the core. Throughout the cycle the block drives a cycle-type status code and the direction and enable lines of the external data transceivers.

A second bus master can take the bus by raising a hold request. The block looks at that request only while it is between cycles. When it grants the bus it raises the acknowledge output and releases every shared pin to high impedance through two output-enable signals. When the hold request drops, the block takes the bus back on the next clock.

Top module: `mux_bus_ctrl`

## Requirements
- R1: When reset is released, the block is idle. In that state `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `status`=3'b111, `dtr`=1, `ad_oe`=0, `ctl_oe`=1, `hlda`=0 and `req_accept`=0.
- R2: A request seen with `req_valid`=1 while idle and `hold`=0 starts a cycle on the next clock. With `rdy` high, the cycle lasts exactly four clocks (T1..T4). `req_accept` is high for the single clock of T4.
- R3: In T1 only, `ale`=1, `ad_oe`=1 and `ad_out` carries the request address.
- R4: In a read, `rd_n` is low from T2 up to the last T3/TW state and high in T1 and T4. `ad_oe` is 0 after T1. `rsp_rdata` holds the value of `ad_in` taken on the edge where ready is accepted, and that value is visible in T4.
- R5: In a write, `wr_n` is low from T2 up to the last T3/TW state. From T2 through T4, `ad_out` carries the write data zero-extended to 20 bits, with `ad_oe`=1.
- R6: `rdy` is sampled only on the edges that end T3 and TW. Each sample at 0 adds one TW clock, so a cycle with N wait states lasts 4+N clocks.
- R7: `status` is 3'b101 for a read and 3'b110 for a write from T1 through the last T3/TW state. It is 3'b111 in T4, while idle and in hold.
- R8: `dtr` is 0 for the whole of a read cycle (T1..T4) and 1 otherwise. `den_n` is low from T2 through T4 and high in T1 and while idle.
- R9: `hold` is sampled only while idle, where it takes priority over a pending request. One clock after it is seen, `hlda`=1 and `ad_oe`=`ctl_oe`=0. A `hold` raised during a cycle neither shortens that cycle nor produces `hlda` before the cycle ends.
- R10: One clock after `hold` falls in the hold state, `hlda`=0 and `ctl_oe`=1. A pending request then starts T1 on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| req_accept | output | 1 | One-clock completion pulse in T4 |
| rsp_rdata | output | 16 | Captured read data |
| ad_out | output | 20 | Value for the shared address/data pins |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | 16 | Data read back from the shared pins |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| status | output | 3 | Cycle-type code |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| ctl_oe | output | 1 | Output enable of strobes, status and transceiver controls |
| rdy | input | 1 | Ready, low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
The bench uses the package defaults: a 20-bit address and 16-bit data. With these widths the zero-extension of write data into the upper four address bits is visible, and the all-ones and all-zero address corners are reachable. The cycle vectors mix reads and writes with zero to five wait states. This shows that every stretched state keeps the strobe, status and transceiver controls steady and moves the accept pulse by exactly one clock per wait. The directed cases cover hold arriving together with a request, hold raised in the middle of a cycle, and the hand-back from hold.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int ST_W   = 3;
    localparam int PAD_W  = ADDR_W - DATA_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_TW,
        PH_T4,
        PH_HOLD
    } phase_e;

    typedef enum logic [ST_W-1:0] {
        CODE_READ    = 3'b101,
        CODE_WRITE   = 3'b110,
        CODE_PASSIVE = 3'b111
    } code_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // strobe window: T2 through the last wait state
    function automatic logic is_strobe(phase_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
    endfunction

    // data window: T2 through T4
    function automatic logic is_data(phase_e p);
        return is_strobe(p) || (p == PH_T4);
    endfunction

    // any state that belongs to a bus cycle
    function automatic logic is_cycle(phase_e p);
        return (p == PH_T1) || is_data(p);
    endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   rdy,
    input  logic   hold,
    output phase_e phase,
    output logic   start,
    output logic   ready_hit
);
    phase_e nxt;

    assign start     = (phase == PH_IDLE) && !hold && req_valid;
    assign ready_hit = ((phase == PH_T3) || (phase == PH_TW)) && rdy;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE: begin
                if (hold)           nxt = PH_HOLD;
                else if (req_valid) nxt = PH_T1;
            end
            PH_T1:   nxt = PH_T2;
            PH_T2:   nxt = PH_T3;
            PH_T3,
            PH_TW:   nxt = rdy ? PH_T4 : PH_TW;
            PH_T4:   nxt = PH_IDLE;
            PH_HOLD: if (!hold) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/mbc_latch.sv
module mbc_latch
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ready_hit,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output xfer_t             cur,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            rdata <= '0;
        end else begin
            if (start) begin
                cur.write <= req_write;
                cur.addr  <= req_addr;
                cur.wdata <= req_wdata;
            end
            if (ready_hit && !cur.write)
                rdata <= ad_in;
        end
    end
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
    import mbc_pkg::*;
(
    input  phase_e            phase,
    input  xfer_t             cur,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ST_W-1:0]   status,
    output logic              dtr,
    output logic              den_n,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              accept
);
    code_e code;

    always_comb begin
        ale    = (phase == PH_T1);
        rd_n   = !(is_strobe(phase) && !cur.write);
        wr_n   = !(is_strobe(phase) &&  cur.write);
        den_n  = !is_data(phase);
        dtr    = !(is_cycle(phase) && !cur.write);
        hlda   = (phase == PH_HOLD);
        ctl_oe = (phase != PH_HOLD);
        accept = (phase == PH_T4);

        ad_oe  = (phase == PH_T1) || (is_data(phase) && cur.write);
        ad_out = cur.addr;
        if (is_data(phase) && cur.write)
            ad_out = {{PAD_W{1'b0}}, cur.wdata};

        code = CODE_PASSIVE;
        if ((phase == PH_T1) || is_strobe(phase))
            code = cur.write ? CODE_WRITE : CODE_READ;
        status = code;
    end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ST_W-1:0]   status,
    output logic              dtr,
    output logic              den_n,
    output logic              ctl_oe,
    input  logic              rdy,
    input  logic              hold,
    output logic              hlda
);
    phase_e phase;
    logic   start;
    logic   ready_hit;
    xfer_t  cur;

    mbc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .rdy       (rdy),
        .hold      (hold),
        .phase     (phase),
        .start     (start),
        .ready_hit (ready_hit)
    );

    mbc_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ready_hit (ready_hit),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .cur       (cur),
        .rdata     (rsp_rdata)
    );

    mbc_drive u_drive (
        .phase  (phase),
        .cur    (cur),
        .ad_out (ad_out),
        .ad_oe  (ad_oe),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .status (status),
        .dtr    (dtr),
        .den_n  (den_n),
        .ctl_oe (ctl_oe),
        .hlda   (hlda),
        .accept (req_accept)
    );
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk
    import mbc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input phase_e phase,
    input logic   rdy,
    input logic   hold,
    input logic   ale,
    input logic   rd_n,
    input logic   wr_n,
    input logic   den_n,
    input logic   ad_oe,
    input logic   ctl_oe,
    input logic   hlda,
    input logic   req_accept
);
    // R3
    ale_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && den_n && rd_n && wr_n));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ale || rd_n || wr_n);

    // R4
    read_float_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R6
    wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
        (((phase == PH_T3) || (phase == PH_TW)) && !rdy)
        |=> ((phase == PH_TW) && $stable(rd_n) && $stable(wr_n)));

    // R9
    hold_float_chk: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ctl_oe));

    // R9
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> ($past(hold) && ($past(phase) == PH_IDLE)));

    // R2
    accept_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_accept |=> !req_accept);

    // R8
    den_t1_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1) |-> den_n);
endmodule

bind mux_bus_ctrl mbc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .rdy        (rdy),
    .hold       (hold),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .den_n      (den_n),
    .ad_oe      (ad_oe),
    .ctl_oe     (ctl_oe),
    .hlda       (hlda),
    .req_accept (req_accept)
);

// File: tb/tb_mux_bus_ctrl.sv
module tb_mux_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_accept;
    logic [15:0] rsp_rdata;
    logic [19:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic        ale, rd_n, wr_n, dtr, den_n, ctl_oe, hlda;
    logic [2:0]  status;
    logic        rdy = 1'b1;
    logic        hold = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mux_bus_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_accept(req_accept),
        .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .status(status), .dtr(dtr),
        .den_n(den_n), .ctl_oe(ctl_oe), .rdy(rdy), .hold(hold), .hlda(hlda)
    );

    // {write, waits[3:0], addr[19:0], data[15:0]}
    localparam logic [40:0] VEC [6] = '{
        {1'b0, 4'd0, 20'hABCDE, 16'h1234},
        {1'b1, 4'd0, 20'h00010, 16'hBEEF},
        {1'b0, 4'd3, 20'hFFFFF, 16'h8001},
        {1'b1, 4'd2, 20'h5A5A5, 16'hFFFF},
        {1'b0, 4'd1, 20'h00000, 16'h0000},
        {1'b1, 4'd5, 20'h80001, 16'h7F00}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({ale, rd_n, wr_n, den_n, dtr, ad_oe, ctl_oe, hlda, req_accept},
            9'b0_1111_0_1_0_0, {tag, " idle controls"});
        chk(status, 3'b111, {tag, " idle status"});
    endtask

    task automatic run_cycle(input logic w, input logic [3:0] nw,
                             input logic [19:0] a, input logic [15:0] d);
        int last;
        last = 3 + int'(nw);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        ad_in = d; rdy = 1'b1;
        for (int k = 0; k <= last; k++) begin
            logic strobe;
            @(negedge clk);
            strobe = (k >= 1) && (k < last);
            // R3
            chk(ale, (k == 0), "R3 ale");
            if (k == 0) chk(ad_out, a, "R3 address");
            // R2 R6
            chk(req_accept, (k == last), "R2/R6 accept timing");
            // R4
            chk(rd_n, !(strobe && !w), "R4 rd_n");
            // R5
            chk(wr_n, !(strobe && w), "R5 wr_n");
            chk(ad_oe, (k == 0) || w, "R4/R5 ad_oe");
            if (w && k > 0) chk(ad_out, {4'h0, d}, "R5 write data");
            // R7
            chk(status, (k < last) ? (w ? 3'b110 : 3'b101) : 3'b111, "R7 status");
            // R8
            chk(dtr, w, "R8 dtr");
            chk(den_n, (k == 0), "R8 den_n");
            chk({hlda, ctl_oe}, 2'b01, "R9 no grant in cycle");
            if (k == last && !w) chk(rsp_rdata, d, "R4 read data");
            rdy = (k >= 2 + int'(nw));
            if (k == last) begin
                req_valid = 1'b0;
                rdy = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");

        // main cycles from table (R2..R8)
        for (int i = 0; i < 6; i++)
            run_cycle(VEC[i][40], VEC[i][39:36], VEC[i][35:16], VEC[i][15:0]);

        @(negedge clk);
        chk_idle("R1 after cycles");

        // R9: hold with pending request has priority
        hold = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345;
        ad_in = 16'hC0DE; rdy = 1'b1;
        @(negedge clk);
        chk({hlda, ad_oe, ctl_oe, ale}, 4'b1000, "R9 grant and float");
        @(negedge clk);
        chk({hlda, ale}, 2'b10, "R9 request held off");

        // R10: release
        hold = 1'b0;
        @(negedge clk);
        chk({hlda, ctl_oe, ale}, 3'b010, "R10 bus regained idle");
        @(negedge clk);
        chk(ale, 1'b1, "R10 pending request starts T1");
        chk(ad_out, 20'h12345, "R10 address");
        repeat (3) @(negedge clk);
        chk(req_accept, 1'b1, "R10 cycle completes");
        chk(rsp_rdata, 16'hC0DE, "R4 read data after hold");
        req_valid = 1'b0;

        // R9: hold raised mid-cycle does not cut it
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0F0F0; req_wdata = 16'h55AA;
        @(negedge clk);
        chk(ale, 1'b1, "R9 mid-cycle T1");
        hold = 1'b1;
        @(negedge clk);
        chk({hlda, wr_n}, 2'b00, "R9 T2 continues");
        @(negedge clk);
        chk({hlda, wr_n}, 2'b00, "R9 T3 continues");
        @(negedge clk);
        chk({hlda, req_accept}, 2'b01, "R9 T4 reached");
        req_valid = 1'b0;
        @(negedge clk);
        chk(hlda, 1'b0, "R9 idle before grant");
        @(negedge clk);
        chk({hlda, ctl_oe, ad_oe}, 3'b100, "R9 grant after cycle");
        hold = 1'b0;
        @(negedge clk);
        chk_idle("R10 back to idle");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule